// File: doc/BRIEF.md
# Two-Stage Pipelined 16-bit Load/Store Core

This block is a compact 16-bit processor that talks to one external memory and to nothing else. The memory is reached through a 16-bit word address, one shared bidirectional data bus and a write strobe. Instructions and data share that single port. The core owns the bus only while it is writing.

A single clock drives everything. Internally that clock is split into two alternating phase enables, so one machine cycle lasts two clocks. In the first phase the core reads the source registers of the instruction held in the execute stage. In the second phase it executes that instruction, writes its result back, and fetches the next instruction into the pipeline register. Branches are resolved in execute, and a taken one discards the word fetched behind it. A load or store takes over the bus in execute, so the fetch of that cycle is held back.

Instruction word layout: opcode in bits [15:12], destination (or store source / first compare operand) in [11:8], first source in [7:4], and second source or signed 4-bit immediate in [3:0].

Top module: `risc16_core`

## Requirements
- R1: A synchronous reset, active high, sets the program counter to 0, puts a NOP (encoding 0x0000) in the pipeline register and clears every register. While reset is held, and in the first clock after it is released, the address bus shows 0 and the write strobe is low.
- R2: Opcodes are 0 NOP, 1 ADD, 2 SUB, 3 AND, 4 OR, 5 XOR, 6 SLT, 7 SLL, 8 SRL, 9 ADDI, A LUI, B LW, C SW, D BEQ, E BNE, F J. ADD/SUB/AND/OR/XOR write rd = rs op rt, with SUB giving rs-rt. SLT writes 1 when rs is less than rt as a signed value, and 0 otherwise.
- R3: ADDI writes rs plus the sign-extended 4-bit immediate. LUI writes bits [7:0] of the instruction into the upper byte of rd and zeros the lower byte. SLL and SRL shift rs by the unsigned amount in bits [3:0], filling with zeros.
- R4: Register 0 always reads as zero. Writes to it are discarded.
- R5: An instruction that reads a register written by the instruction just before it, including a load, gets the new value without any forwarding stall.
- R6: LW loads and SW stores at rs plus the sign-extended immediate. SW stores rd. The core drives the data bus only while the write strobe is high.
- R7: A load or store holds back the next fetch by exactly one machine cycle.
- R8: BEQ branches when rd equals rs, and BNE branches when they differ. The target is the branch address plus 1 plus the sign-extended immediate, and backward targets work. A branch that is not taken falls through.
- R9: J loads bits [11:0] of the instruction into the low 12 bits of the PC. A taken branch or jump discards the instruction fetched behind it, which costs exactly one machine cycle.
- R10: A machine cycle is two clocks. Memory access for a load or store, and the write strobe, happen only in the second clock. The write strobe stays high for exactly one clock per store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; both phases are enables derived from it |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address: the PC for fetches, the effective address for loads and stores |
| mem_data | inout | 16 | Shared data bus; the core drives it only while mem_we is high |
| mem_we | output | 1 | Memory write strobe, high during the execute phase of a store |

## Verification
Each test is a short program run against a word-array memory. Register results are made visible by storing them to memory. The first set of programs covers the ALU with one positive and one negative operand, which separates signed from unsigned comparison and AND from OR from XOR. Constants are built with LUI and then shifted by small and maximal amounts. A program aimed at register 0 checks that a write to it has no effect and that it reads back as zero.

Control flow is tested with a forward taken BEQ, a BNE that is not taken, a backward loop and a jump. The value of each skipped instruction shows whether the flush happened. A load whose result is used straight away, followed by a chain of dependent ALU operations, separates correct write-then-read ordering from stale operands. Two timing programs count clocks from reset to the first store strobe. One count separates a one-cycle flush from none or two. The other separates a one-cycle memory stall from none. Both also check the bus address and how long the strobe lasts.

// File: rtl/risc16_core.sv
module risc16_core (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] mem_addr,
  inout  wire  [15:0] mem_data,
  output logic        mem_we
);

  localparam logic [3:0] OP_NOP  = 4'h0;
  localparam logic [3:0] OP_ADD  = 4'h1;
  localparam logic [3:0] OP_SUB  = 4'h2;
  localparam logic [3:0] OP_AND  = 4'h3;
  localparam logic [3:0] OP_OR   = 4'h4;
  localparam logic [3:0] OP_XOR  = 4'h5;
  localparam logic [3:0] OP_SLT  = 4'h6;
  localparam logic [3:0] OP_SLL  = 4'h7;
  localparam logic [3:0] OP_SRL  = 4'h8;
  localparam logic [3:0] OP_ADDI = 4'h9;
  localparam logic [3:0] OP_LUI  = 4'hA;
  localparam logic [3:0] OP_LW   = 4'hB;
  localparam logic [3:0] OP_SW   = 4'hC;
  localparam logic [3:0] OP_BEQ  = 4'hD;
  localparam logic [3:0] OP_BNE  = 4'hE;
  localparam logic [3:0] OP_J    = 4'hF;
  localparam logic [15:0] BUBBLE = 16'h0000;

  logic        ph;
  logic [15:0] pc, ir, opa, opb;
  logic [15:0] rf [16];

  logic [3:0]  op, rd, rs, rt;
  assign op = ir[15:12];
  assign rd = ir[11:8];
  assign rs = ir[7:4];
  assign rt = ir[3:0];

  logic [15:0] simm;
  assign simm = {{12{ir[3]}}, ir[3:0]};

  logic rtype, is_mem, writes_rd, taken;
  assign rtype  = (op >= OP_ADD) && (op <= OP_SLT);
  assign is_mem = (op == OP_LW) || (op == OP_SW);
  assign writes_rd = ((op >= OP_ADD) && (op <= OP_LUI)) || (op == OP_LW);
  assign taken  = ph && (((op == OP_BEQ) && (opa == opb)) ||
                         ((op == OP_BNE) && (opa != opb)) ||
                         (op == OP_J));

  logic [15:0] ea;
  assign ea = opa + simm;

  assign mem_addr = (ph && is_mem) ? ea : pc;
  assign mem_we   = ph && (op == OP_SW);
  assign mem_data = mem_we ? opb : 16'hzzzz;

  logic [15:0] alu;
  always_comb begin
    case (op)
      OP_ADD:  alu = opa + opb;
      OP_SUB:  alu = opa - opb;
      OP_AND:  alu = opa & opb;
      OP_OR:   alu = opa | opb;
      OP_XOR:  alu = opa ^ opb;
      OP_SLT:  alu = {15'd0, $signed(opa) < $signed(opb)};
      OP_SLL:  alu = opa << rt;
      OP_SRL:  alu = opa >> rt;
      OP_ADDI: alu = opa + simm;
      OP_LUI:  alu = {ir[7:0], 8'h00};
      default: alu = 16'h0000;
    endcase
  end

  logic        wr_en;
  logic [15:0] wdata;
  assign wr_en = ph && writes_rd && (rd != 4'd0);
  assign wdata = (op == OP_LW) ? mem_data : alu;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) rf[i] <= 16'h0000;
    end else if (wr_en) begin
      rf[rd] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= 1'b0;
      pc  <= 16'h0000;
      ir  <= BUBBLE;
      opa <= 16'h0000;
      opb <= 16'h0000;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        opa <= rf[rs];
        opb <= rtype ? rf[rt] : rf[rd];
      end else if (taken) begin
        ir <= BUBBLE;
        pc <= (op == OP_J) ? {pc[15:12], ir[11:0]} : pc + simm;
      end else if (is_mem) begin
        ir <= BUBBLE;
      end else begin
        ir <= mem_data;
        pc <= pc + 16'd1;
      end
    end
  end

  p_r0_zero_r4: assert property (@(posedge clk) disable iff (rst)
    rf[0] == 16'h0000);

  p_we_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_pc_hold_phase1_r10: assert property (@(posedge clk) disable iff (rst)
    !ph |=> $stable(pc));

  p_phase_alternate_r10: assert property (@(posedge clk) disable iff (rst)
    ph |=> !ph);

  p_mem_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (ph && is_mem) |=> (ir == BUBBLE && $stable(pc)));

  p_flush_r9: assert property (@(posedge clk) disable iff (rst)
    taken |=> ir == BUBBLE);

endmodule

// File: tb/tb_risc16_core.sv
module tb_risc16_core;

  localparam logic [3:0] NOP = 4'h0, ADD = 4'h1, SUB = 4'h2, AND_ = 4'h3,
                         OR_ = 4'h4, XOR_ = 4'h5, SLT = 4'h6, SLL = 4'h7,
                         SRL = 4'h8, ADDI = 4'h9, LUI = 4'hA, LW = 4'hB,
                         SW = 4'hC, BEQ = 4'hD, BNE = 4'hE, JMP = 4'hF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  wire  [15:0] mem_data;
  logic        mem_we;

  logic [15:0] prog [512];
  logic [15:0] mem  [512];

  int n_checks = 0;
  int n_fails  = 0;
  int clocks   = 0;

  risc16_core dut (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we));

  always #4 clk = ~clk;

  assign mem_data = mem_we ? 16'hzzzz : mem[mem_addr[8:0]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 512; i++) mem[i] <= prog[i];
    end else if (mem_we) begin
      mem[mem_addr[8:0]] <= mem_data;
    end
  end

  always @(posedge clk) begin
    clocks <= clocks + 1;
    if (clocks == 100000) begin
      n_fails  = n_fails + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  function automatic logic [15:0] enc(logic [3:0] op, logic [3:0] a, logic [3:0] b, logic [3:0] c);
    return {op, a, b, c};
  endfunction

  function automatic logic [15:0] encl(logic [3:0] rd, logic [7:0] imm);
    return {LUI, rd, imm};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fails = n_fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 512; i++) prog[i] = 16'h0000;
    for (int i = 256; i < 264; i++) prog[i] = 16'hBEEF;
  endtask

  task automatic start();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(int cyc);
    start();
    repeat (cyc) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    clear_prog();
    prog[0] = enc(JMP, 4'h0, 4'h0, 4'h0);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 addr in reset", mem_addr, 16'h0000);
    check("R1 we in reset", {15'd0, mem_we}, 16'h0000);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 addr after release", mem_addr, 16'h0000);
    check("R1 we after release", {15'd0, mem_we}, 16'h0000);
  endtask

  task automatic t_alu();
    logic [15:0] a, b;
    a = 16'd5;
    b = 16'hFFFD;
    clear_prog();
    prog[0]  = encl(4'd14, 8'h01);
    prog[1]  = enc(ADDI, 4'd1, 4'd0, 4'd5);
    prog[2]  = enc(ADDI, 4'd2, 4'd0, 4'hD);
    prog[3]  = enc(ADD,  4'd3, 4'd1, 4'd2);
    prog[4]  = enc(SUB,  4'd4, 4'd1, 4'd2);
    prog[5]  = enc(AND_, 4'd5, 4'd1, 4'd2);
    prog[6]  = enc(OR_,  4'd6, 4'd1, 4'd2);
    prog[7]  = enc(XOR_, 4'd7, 4'd1, 4'd2);
    prog[8]  = enc(SLT,  4'd8, 4'd2, 4'd1);
    prog[9]  = enc(SLT,  4'd9, 4'd1, 4'd2);
    for (int k = 0; k < 7; k++) prog[10 + k] = enc(SW, 4'(3 + k), 4'd14, 4'(k));
    prog[17] = enc(JMP, 4'h0, 4'h0, 4'd17);
    run(300);
    check("R2 ADD", mem[256], a + b);
    check("R2 SUB", mem[257], a - b);
    check("R2 AND", mem[258], a & b);
    check("R2 OR",  mem[259], a | b);
    check("R2 XOR", mem[260], a ^ b);
    check("R2 SLT true",  mem[261], 16'd1);
    check("R2 SLT false", mem[262], 16'd0);
  endtask

  task automatic t_shift_lui();
    clear_prog();
    prog[0] = encl(4'd1, 8'hA5);
    prog[1] = enc(SRL, 4'd2, 4'd1, 4'd4);
    prog[2] = enc(SLL, 4'd3, 4'd1, 4'd3);
    prog[3] = enc(SRL, 4'd4, 4'd1, 4'd15);
    prog[4] = enc(ADDI, 4'd5, 4'd1, 4'h8);
    prog[5] = encl(4'd14, 8'h01);
    for (int k = 0; k < 5; k++) prog[6 + k] = enc(SW, 4'(1 + k), 4'd14, 4'(k));
    prog[11] = enc(JMP, 4'h0, 4'h0, 4'd11);
    run(300);
    check("R3 LUI", mem[256], 16'hA500);
    check("R3 SRL 4", mem[257], 16'hA500 >> 4);
    check("R3 SLL 3", mem[258], 16'(16'hA500 << 3));
    check("R3 SRL 15", mem[259], 16'h0001);
    check("R3 ADDI negative", mem[260], 16'hA500 - 16'd8);
  endtask

  task automatic t_zero();
    clear_prog();
    prog[0] = enc(ADDI, 4'd0, 4'd0, 4'd7);
    prog[1] = enc(ADD, 4'd1, 4'd0, 4'd0);
    prog[2] = enc(ADDI, 4'd2, 4'd0, 4'hF);
    prog[3] = encl(4'd14, 8'h01);
    prog[4] = enc(SW, 4'd0, 4'd14, 4'd0);
    prog[5] = enc(SW, 4'd1, 4'd14, 4'd1);
    prog[6] = enc(SW, 4'd2, 4'd14, 4'd2);
    prog[7] = enc(JMP, 4'h0, 4'h0, 4'd7);
    run(200);
    check("R4 store r0", mem[256], 16'h0000);
    check("R4 r0+r0", mem[257], 16'h0000);
    check("R4 r0 plus -1", mem[258], 16'hFFFF);
  endtask

  task automatic t_load_use();
    clear_prog();
    prog[255] = 16'h0123;
    prog[0] = encl(4'd14, 8'h01);
    prog[1] = enc(LW,   4'd1, 4'd14, 4'hF);
    prog[2] = enc(ADD,  4'd2, 4'd1, 4'd1);
    prog[3] = enc(ADDI, 4'd3, 4'd2, 4'd1);
    prog[4] = enc(SW,   4'd2, 4'd14, 4'd0);
    prog[5] = enc(SW,   4'd3, 4'd14, 4'd1);
    prog[6] = enc(SW,   4'd1, 4'd14, 4'h8);
    prog[7] = enc(JMP, 4'h0, 4'h0, 4'd7);
    run(200);
    check("R5 load then use", mem[256], 16'h0246);
    check("R5 ALU then use", mem[257], 16'h0247);
    check("R6 negative offset store", mem[248], 16'h0123);
  endtask

  task automatic t_branch();
    clear_prog();
    prog[0]  = enc(ADDI, 4'd1, 4'd0, 4'd1);
    prog[1]  = encl(4'd14, 8'h01);
    prog[2]  = enc(BEQ,  4'd1, 4'd1, 4'd1);
    prog[3]  = enc(ADDI, 4'd2, 4'd0, 4'd7);
    prog[4]  = enc(ADDI, 4'd3, 4'd0, 4'd3);
    prog[5]  = enc(BNE,  4'd0, 4'd0, 4'd2);
    prog[6]  = enc(ADDI, 4'd4, 4'd0, 4'd4);
    prog[7]  = enc(ADDI, 4'd5, 4'd0, 4'd3);
    prog[8]  = enc(ADDI, 4'd6, 4'd6, 4'd2);
    prog[9]  = enc(ADDI, 4'd5, 4'd5, 4'hF);
    prog[10] = enc(BNE,  4'd5, 4'd0, 4'hD);
    prog[11] = enc(SW, 4'd2, 4'd14, 4'd0);
    prog[12] = enc(SW, 4'd3, 4'd14, 4'd1);
    prog[13] = enc(SW, 4'd4, 4'd14, 4'd2);
    prog[14] = enc(SW, 4'd6, 4'd14, 4'd3);
    prog[15] = enc(JMP, 4'h0, 4'h0, 4'd15);
    run(400);
    check("R8 BEQ taken skips", mem[256], 16'd0);
    check("R8 BEQ target reached", mem[257], 16'd3);
    check("R8 BNE not taken falls through", mem[258], 16'd4);
    check("R8 backward loop count", mem[259], 16'd6);
  endtask

  task automatic t_jump();
    clear_prog();
    prog[0] = enc(JMP, 4'h0, 4'h0, 4'd3);
    prog[1] = enc(ADDI, 4'd1, 4'd0, 4'd7);
    prog[2] = enc(ADDI, 4'd1, 4'd0, 4'd6);
    prog[3] = enc(ADDI, 4'd2, 4'd0, 4'd2);
    prog[4] = encl(4'd14, 8'h01);
    prog[5] = enc(SW, 4'd1, 4'd14, 4'd0);
    prog[6] = enc(SW, 4'd2, 4'd14, 4'd1);
    prog[7] = enc(JMP, 4'h0, 4'h0, 4'd7);
    run(200);
    check("R9 jump flushes next", mem[256], 16'd0);
    check("R9 jump target", mem[257], 16'd2);
  endtask

  task automatic t_flush_timing();
    int first_we;
    int n;
    logic [15:0] addr_at;
    logic we_after;
    clear_prog();
    prog[0] = enc(ADDI, 4'd1, 4'd0, 4'd1);
    prog[1] = enc(BEQ,  4'd0, 4'd0, 4'd1);
    prog[2] = enc(NOP,  4'd0, 4'd0, 4'd0);
    prog[3] = enc(SW,   4'd1, 4'd0, 4'd7);
    prog[4] = enc(JMP, 4'h0, 4'h0, 4'd4);
    first_we = -1;
    addr_at  = 16'hFFFF;
    we_after = 1'b1;
    start();
    n = -1;
    for (int c = 0; c < 40; c++) begin
      @(posedge clk);
      @(negedge clk);
      n = n + 1;
      if (first_we < 0 && mem_we) begin
        first_we = n;
        addr_at  = mem_addr;
      end else if (first_we >= 0 && n == first_we + 1) begin
        we_after = mem_we;
      end
    end
    check("R9 flush costs one cycle", 16'(first_we), 16'd8);
    check("R10 store address in phase 2", addr_at, 16'd7);
    check("R10 strobe one clock", {15'd0, we_after}, 16'd0);
    check("R6 stored value", mem[7], 16'd1);
  endtask

  task automatic t_stall_timing();
    int first_we;
    int n;
    logic [15:0] addr_load;
    logic we_load;
    clear_prog();
    prog[7] = 16'h1234;
    prog[0] = enc(LW, 4'd1, 4'd0, 4'd7);
    prog[1] = enc(SW, 4'd1, 4'd0, 4'd6);
    prog[2] = enc(JMP, 4'h0, 4'h0, 4'd2);
    first_we  = -1;
    addr_load = 16'hFFFF;
    we_load   = 1'b1;
    start();
    n = -1;
    for (int c = 0; c < 40; c++) begin
      @(posedge clk);
      @(negedge clk);
      n = n + 1;
      if (n == 2) begin
        addr_load = mem_addr;
        we_load   = mem_we;
      end
      if (first_we < 0 && mem_we) first_we = n;
    end
    check("R7 memory stall one cycle", 16'(first_we), 16'd6);
    check("R6 load address on bus", addr_load, 16'd7);
    check("R6 no strobe for load", {15'd0, we_load}, 16'd0);
    check("R6 load then store", mem[6], 16'h1234);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_shift_lui();
    t_zero();
    t_load_use();
    t_branch();
    t_jump();
    t_flush_timing();
    t_stall_timing();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule